// File: doc/BRIEF.md
# Copy Queue Channel Sequencer

This block governs one channel of a descriptor-driven copy engine. Software steers it through three control bits held in a small word-addressed register file: enable, pause and abort-on-error. A fourth, write-only bit asks for a queue reset. A companion datapath reports each finished descriptor as done or failed, and a ring engine reports whether work is pending. In return the block grants the ring engine permission to fetch one descriptor at a time, and it drives a flush strobe while internal buffers and ring pointers are being cleared.

The channel's condition is published as a 4-bit code. The code is available on a port and in a read-only status word, so that a shutdown routine can poll it. That routine sets pause, clears enable, waits until the code is no longer RUN, requests a reset and then releases pause. The block supports this sequence: a descriptor that is in flight always finishes before the channel settles, and every reset ends in IDLE after a fixed flush period.

Top module: `qchan_ctrl`

## Requirements
- R1: After `rst_n` is released, the state is IDLE (0), `fetch_ok` and `flush` are low, and control word 0 reads as zero.
- R2: The state codes are IDLE=0, RUN=1, CPL=2, PAUSE=3, HALT=4, ABORT=5, WAIT=6, BUFFCLR=7. The code appears on `state_o` and in bits [3:0] of the status word at address 2, and bits [31:4] of that word read zero.
- R3: A channel in IDLE moves to RUN only when enable is set, pause is clear and `work_pend` is high. While in RUN with no descriptor in flight, `fetch_ok` is high. Each cycle in which `fetch_ok` and `work_pend` are both high places one descriptor in flight, and `fetch_ok` then drops until that descriptor retires.
- R4: In RUN, when `work_pend` is low and no descriptor remains in flight, the channel spends exactly one cycle in CPL and then returns to IDLE.
- R5: Setting pause while a descriptor is in flight moves RUN to WAIT. A retire event then moves WAIT to PAUSE. `fetch_ok` stays low in both states. Clearing pause with enable set returns the channel to RUN.
- R6: Clearing enable (with pause clear) while a descriptor is in flight passes through WAIT to HALT. The channel stays in HALT until enable is set again, and then goes to IDLE.
- R7: When the abort policy bit is 0, `desc_err` retires the in-flight descriptor and the channel stays in RUN, with `fetch_ok` high again.
- R8: When the abort policy bit is 1, `desc_err` in RUN or WAIT moves the channel to ABORT. Writes to control word 0 do not move it out of ABORT; only a reset request does.
- R9: Writing 1 to bit 0 at address 1 enters BUFFCLR on the next clock edge, from any state. The channel stays in BUFFCLR with `flush` high for exactly FLUSH_CYC cycles, then enters IDLE. Control word 0 is preserved, the in-flight marker is cleared, and bit 0 at address 1 reads 1 only during BUFFCLR.
- R10: A reset request takes precedence over a `desc_err` or `desc_done` event in the same cycle: the channel enters BUFFCLR and not ABORT.
- R11: Control word 0 at address 0 holds enable in bit 0, pause in bit 4 and the abort policy in bit 8, and all its other bits read zero. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| work_pend | input | 1 | The ring holds unfetched descriptors |
| desc_done | input | 1 | The in-flight descriptor completed |
| desc_err | input | 1 | The in-flight descriptor failed |
| fetch_ok | output | 1 | Permission to fetch one descriptor |
| flush | output | 1 | Buffer and ring-pointer clear in progress |
| state_o | output | 4 | Current channel state code |

## Verification
The collision that matters most is a reset request that lands in the same cycle as a descriptor error while the abort policy is armed. One path would lead to the sticky ABORT state and the other to BUFFCLR. The bench starts a descriptor, then drives the reset write and `desc_err` on the same clock edge. It passes the test only if the next state is BUFFCLR, the flush lasts the full period, and the channel then fetches again with no descriptor marked in flight. A second overlap, a pause arriving while a descriptor is still outstanding, is provoked by holding the retire event back. This confirms the WAIT detour before the channel settles in PAUSE.

// File: rtl/qchan_ctrl.sv
`timescale 1ns/1ps
module qchan_ctrl #(
  parameter int FLUSH_CYC = 4,
  parameter int AW        = 2,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          work_pend,
  input  logic          desc_done,
  input  logic          desc_err,
  output logic          fetch_ok,
  output logic          flush,
  output logic [3:0]    state_o
);

  localparam int CW        = $clog2(FLUSH_CYC) + 1;
  localparam int EN_BIT    = 0;
  localparam int PAUSE_BIT = 4;
  localparam int ABORT_BIT = 8;
  localparam int RST_BIT   = 0;
  localparam logic [AW-1:0] A_CTRL0 = AW'(0);
  localparam logic [AW-1:0] A_CTRL1 = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);
  localparam logic [CW-1:0] CLR_LOAD = CW'(FLUSH_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_RUN   = 4'd1,
    S_CPL   = 4'd2,
    S_PAUSE = 4'd3,
    S_HALT  = 4'd4,
    S_ABORT = 4'd5,
    S_WAIT  = 4'd6,
    S_CLR   = 4'd7
  } qstate_e;

  qstate_e       st, nxt;
  logic          en_q, pause_q, abort_q, busy;
  logic [CW-1:0] cnt;
  logic          rst_req, retire, settled, unused_wdata;

  assign rst_req  = reg_wr && (reg_addr == A_CTRL1) && reg_wdata[RST_BIT];
  assign retire   = desc_done || desc_err;
  assign settled  = !busy || retire;
  assign fetch_ok = (st == S_RUN) && !busy;
  assign flush    = (st == S_CLR);
  assign state_o  = st;
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    nxt = st;
    if (rst_req) begin
      nxt = S_CLR;
    end else begin
      unique case (st)
        S_IDLE:  if (en_q && !pause_q && work_pend) nxt = S_RUN;
        S_RUN: begin
          if (desc_err && abort_q)          nxt = S_ABORT;
          else if (pause_q || !en_q)        nxt = !settled ? S_WAIT : (pause_q ? S_PAUSE : S_HALT);
          else if (!work_pend && settled)   nxt = S_CPL;
        end
        S_WAIT: begin
          if (desc_err && abort_q)          nxt = S_ABORT;
          else if (settled)                 nxt = pause_q ? S_PAUSE : (!en_q ? S_HALT : S_RUN);
        end
        S_PAUSE: if (!pause_q) nxt = en_q ? S_RUN : S_HALT;
        S_HALT:  if (en_q && !pause_q) nxt = S_IDLE;
        S_CPL:   nxt = S_IDLE;
        S_ABORT: nxt = S_ABORT;
        S_CLR:   if (cnt == '0) nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      st <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (rst_req || retire) begin
      busy <= 1'b0;
    end else if (fetch_ok && work_pend) begin
      busy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (rst_req) begin
      cnt <= CLR_LOAD;
    end else if (st == S_CLR && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL0) begin
      en_q    <= reg_wdata[EN_BIT];
      pause_q <= reg_wdata[PAUSE_BIT];
      abort_q <= reg_wdata[ABORT_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL0: begin
        reg_rdata[EN_BIT]    = en_q;
        reg_rdata[PAUSE_BIT] = pause_q;
        reg_rdata[ABORT_BIT] = abort_q;
      end
      A_CTRL1: reg_rdata[RST_BIT] = (st == S_CLR);
      A_STAT:  reg_rdata[3:0] = st;
      default: reg_rdata = '0;
    endcase
  end

endmodule

module qchan_ctrl_chk #(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          desc_err,
  input logic          fetch_ok,
  input logic          flush,
  input logic [3:0]    state_o,
  input logic          q_en,
  input logic          q_pause,
  input logic          q_abort
);

  logic rq;
  assign rq = reg_wr && (reg_addr == AW'(1)) && reg_wdata[0];

  AST_RST_ENTERS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rq |=> state_o == 4'd7); // R9

  AST_CLR_EXITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> state_o == 4'd0); // R9

  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd5 && !rq) |=> state_o == 4'd5); // R8

  AST_CPL_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd2 && !rq) |=> state_o == 4'd0); // R4

  AST_NO_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd3 || state_o == 4'd6 || state_o == 4'd4 || state_o == 4'd5 || state_o == 4'd7) |-> !fetch_ok); // R5

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd1 && $past(state_o) == 4'd0) |-> ($past(q_en) && !$past(q_pause))); // R3

  AST_ERR_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd1 && desc_err && !q_abort && !rq) |=> state_o != 4'd5); // R7

  AST_HALT_WAITS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd4 && !q_en && !rq) |=> state_o == 4'd4); // R6

endmodule

bind qchan_ctrl qchan_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .desc_err(desc_err), .fetch_ok(fetch_ok),
  .flush(flush), .state_o(state_o), .q_en(en_q), .q_pause(pause_q),
  .q_abort(abort_q)
);

// File: tb/qchan_ctrl_tb_top.sv
`timescale 1ns/1ps
module qchan_ctrl_tb_top;
  localparam int FC = 4;
  localparam logic [31:0] EN = 32'h1, PA = 32'h10, AB = 32'h100;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        work_pend = 0, desc_done = 0, desc_err = 0;
  logic        fetch_ok, flush;
  logic [3:0]  state_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  qchan_ctrl #(.FLUSH_CYC(FC), .AW(2), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .work_pend(work_pend),
    .desc_done(desc_done), .desc_err(desc_err), .fetch_ok(fetch_ok),
    .flush(flush), .state_o(state_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse_done;
    desc_done = 1; tick(1); desc_done = 0;
  endtask

  task automatic pulse_err;
    desc_err = 1; tick(1); desc_err = 0;
  endtask

  task automatic drain;
    work_pend = 0;
    pulse_done();
    tick(1);
    chk("R4 drain to IDLE", {28'd0, state_o}, 32'd0);
  endtask

  task automatic wait_flush(output int n);
    n = 0;
    while (flush && n < 50) begin
      n++; tick(1);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 state", {28'd0, state_o}, 32'd0);
    chk("R1 fetch_ok", {31'd0, fetch_ok}, 32'd0);
    chk("R1 flush", {31'd0, flush}, 32'd0);
    rd(2'd0, d); chk("R1 ctrl0", d, 32'd0);
  endtask

  task automatic t_start_drain;
    logic [31:0] d;
    work_pend = 1;
    wr(2'd0, EN);
    chk("R3 still IDLE", {28'd0, state_o}, 32'd0);
    tick(1);
    chk("R3 RUN", {28'd0, state_o}, 32'd1);
    chk("R3 fetch permit", {31'd0, fetch_ok}, 32'd1);
    rd(2'd2, d); chk("R2 status code RUN", d, 32'd1);
    tick(1);
    chk("R3 one in flight", {31'd0, fetch_ok}, 32'd0);
    work_pend = 0;
    pulse_done();
    chk("R4 CPL", {28'd0, state_o}, 32'd2);
    rd(2'd2, d); chk("R2 status code CPL", d, 32'd2);
    tick(1);
    chk("R4 back to IDLE", {28'd0, state_o}, 32'd0);
  endtask

  task automatic t_pause;
    work_pend = 1;
    tick(1);
    chk("R5 RUN", {28'd0, state_o}, 32'd1);
    tick(1);
    wr(2'd0, EN | PA);
    tick(1);
    chk("R5 WAIT", {28'd0, state_o}, 32'd6);
    tick(2);
    chk("R5 WAIT held", {28'd0, state_o}, 32'd6);
    chk("R5 no fetch in WAIT", {31'd0, fetch_ok}, 32'd0);
    pulse_done();
    chk("R5 PAUSE", {28'd0, state_o}, 32'd3);
    chk("R5 no fetch in PAUSE", {31'd0, fetch_ok}, 32'd0);
    wr(2'd0, EN);
    tick(1);
    chk("R5 resumed RUN", {28'd0, state_o}, 32'd1);
    chk("R5 fetch after resume", {31'd0, fetch_ok}, 32'd1);
    drain();
  endtask

  task automatic t_halt;
    work_pend = 1;
    tick(1);
    tick(1);
    wr(2'd0, 32'd0);
    tick(1);
    chk("R6 WAIT", {28'd0, state_o}, 32'd6);
    pulse_done();
    chk("R6 HALT", {28'd0, state_o}, 32'd4);
    tick(3);
    chk("R6 HALT held", {28'd0, state_o}, 32'd4);
    wr(2'd0, EN);
    tick(1);
    chk("R6 to IDLE", {28'd0, state_o}, 32'd0);
    tick(1);
    chk("R6 restart RUN", {28'd0, state_o}, 32'd1);
    drain();
  endtask

  task automatic t_err_continue;
    work_pend = 1;
    tick(1);
    tick(1);
    chk("R7 in flight", {31'd0, fetch_ok}, 32'd0);
    pulse_err();
    chk("R7 stays RUN", {28'd0, state_o}, 32'd1);
    chk("R7 fetch again", {31'd0, fetch_ok}, 32'd1);
    drain();
  endtask

  task automatic t_err_abort;
    logic [31:0] d;
    int n;
    wr(2'd0, EN | AB);
    work_pend = 1;
    tick(1);
    chk("R8 RUN", {28'd0, state_o}, 32'd1);
    tick(1);
    pulse_err();
    chk("R8 ABORT", {28'd0, state_o}, 32'd5);
    chk("R8 no fetch", {31'd0, fetch_ok}, 32'd0);
    wr(2'd0, EN); tick(2);
    wr(2'd0, EN | PA); tick(2);
    wr(2'd0, 32'd0); tick(2);
    chk("R8 sticky ABORT", {28'd0, state_o}, 32'd5);
    wr(2'd0, EN | PA);
    wr(2'd1, 32'd1);
    chk("R9 BUFFCLR", {28'd0, state_o}, 32'd7);
    chk("R9 flush", {31'd0, flush}, 32'd1);
    rd(2'd1, d); chk("R9 reset bit busy", d, 32'd1);
    wait_flush(n);
    chk("R9 flush length", n, FC);
    chk("R9 IDLE after flush", {28'd0, state_o}, 32'd0);
    rd(2'd0, d); chk("R9 ctrl0 kept", d, EN | PA);
    rd(2'd1, d); chk("R9 reset bit clear", d, 32'd0);
    tick(2);
    chk("R3 pause blocks start", {28'd0, state_o}, 32'd0);
    work_pend = 0;
    wr(2'd0, 32'd0);
  endtask

  task automatic t_collide;
    int n;
    wr(2'd0, EN | AB);
    work_pend = 1;
    tick(1);
    tick(1);
    chk("R10 in flight", {31'd0, fetch_ok}, 32'd0);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'd1; desc_err = 1;
    tick(1);
    reg_wr = 0; reg_wdata = 0; desc_err = 0;
    chk("R10 reset wins", {28'd0, state_o}, 32'd7);
    wait_flush(n);
    chk("R10 flush length", n, FC);
    chk("R10 IDLE", {28'd0, state_o}, 32'd0);
    tick(1);
    chk("R9 busy cleared RUN", {28'd0, state_o}, 32'd1);
    chk("R9 busy cleared fetch", {31'd0, fetch_ok}, 32'd1);
    work_pend = 0;
    tick(2);
    chk("R4 idle after collide", {28'd0, state_o}, 32'd0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R11 ctrl0 fields", d, 32'h111);
    rd(2'd3, d); chk("R11 addr3", d, 32'd0);
    rd(2'd2, d); chk("R2 status upper zero", d, 32'd0);
    wr(2'd0, 32'd0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_start_drain();
    t_pause();
    t_halt();
    t_err_continue();
    t_err_abort();
    t_collide();
    t_regmap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule